// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Port-to-Port Forwarding

This block is a shared memory with two independent access ports, X and Y. Each port has its own address, write data, write enable, forward request, output enable and registered read output. Both ports can reach any word of a single array. In any clock cycle each port may read or write. Either port may also forward its write data to the opposite port's output, in place of a read. The word count (set by `ADDR_W`) and the word width (`WIDTH`) are parameters. A 15-bit address with 36-bit words gives the full-size configuration. The default is kept smaller so that the array stays modest at elaboration.

Every address, data, write, forward and chip-enable input is captured in an input register on the rising clock edge. On the next edge the array is accessed and each port's output register loads its result. A result therefore appears two rising edges after its inputs were presented. Fixed rules settle two ports touching the same word. Two reads both return the word. A read that meets a write returns the contents from before the write. Two writes leave port Y's data in the array. The block responds only while the active-low select is low and the active-high select is high.

A small start-up state machine has two states, `ST_WARM` and `ST_RUN`. Reset puts it in `ST_WARM`. The first rising edge moves it to `ST_RUN` (transition "warm done"), and whatever was captured on that edge is discarded. It then stays in `ST_RUN` until the next reset. Each port's output register holds one of three sources: `OUT_NONE` (nothing to show), `OUT_ARRAY` (the array word) or `OUT_FWD` (the other port's forwarded data). It reloads on every edge. The output enables are not registered. Each one gates its port's valid flag and data bus without waiting for a clock edge.

Top module: `dpf_ram`

## Requirements
- R1: Inputs are captured on a rising edge, and the resulting read data appears on the port output after the following rising edge. A result is visible two edges after its inputs were applied and not after the first.
- R2: A selected port with its write enable high stores its data at its address. A later read of that address from either port returns the stored word.
- R3: With port X's forward request high, X's write data appears on port Y's output with read latency. Port Y's forward request does the same from Y to X, and both directions can run in the same cycle.
- R4: When a port is reading and the opposite port forwards in the same cycle, the reading port's output shows the forwarded data and not the array word.
- R5: Two reads of the same address in one cycle both return the stored word.
- R6: When one port writes an address and the other reads that address in the same cycle, the read returns the contents from before the write.
- R7: When both ports write the same address in one cycle, port Y's data is stored and port X's data is discarded.
- R8: The block is selected only when the active-low select is 0 and the active-high select is 1, as captured on the edge. While deselected nothing is written and both valid flags are 0 for that access.
- R9: A port's valid flag is 1 only when its output register holds a result and its output enable is 1. The output enable acts without a clock edge. While the valid flag is 0 the data bus reads as all zeros.
- R10: After reset is released, the inputs captured on the first rising edge are ignored: no write takes place and no output result is produced.
- R11: During reset, and for a port that writes without receiving forwarded data, the valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all captures on rising edge |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| x_addr | input | ADDR_W | Port X word address |
| x_wdata | input | WIDTH | Port X write / forward data |
| x_we | input | 1 | Port X write enable (1 = write, 0 = read) |
| x_fwd | input | 1 | Forward port X data to port Y output |
| x_oe | input | 1 | Port X output enable, not registered |
| x_rdata | output | WIDTH | Port X output data, zero when not valid |
| x_valid | output | 1 | Port X output holds a result and is enabled |
| y_addr | input | ADDR_W | Port Y word address |
| y_wdata | input | WIDTH | Port Y write / forward data |
| y_we | input | 1 | Port Y write enable (1 = write, 0 = read) |
| y_fwd | input | 1 | Forward port Y data to port X output |
| y_oe | input | 1 | Port Y output enable, not registered |
| y_rdata | output | WIDTH | Port Y output data, zero when not valid |
| y_valid | output | 1 | Port Y output holds a result and is enabled |

## Verification
Several functions can land in the same cycle and must be resolved by a fixed rule. A forward from one port can meet a read on the other port, a write can meet a read at one address, and two writes can hit one address. The stimulus table sets up each of these pairings deliberately: a read together with an incoming forward, a read and a write to a shared address, two writes to one address, and forwards running both ways at once. Each result is checked two edges after it was applied, against the word the rule selects, and the losing word is chosen to differ from the winner so that a wrong outcome is visible. Directed tests then cover the ignored first edge, the two select inputs and the clock-free output enable.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    // Start-up sequencer states
    typedef enum logic {
        ST_WARM,
        ST_RUN
    } boot_st_e;

    // What a port's output register currently holds
    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_ARRAY,
        OUT_FWD
    } out_src_e;

endpackage

// File: rtl/dpf_array.sv
module dpf_array #(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_x,
    input  logic [ADDR_W-1:0] addr_x,
    input  logic [WIDTH-1:0]  din_x,
    input  logic              wr_y,
    input  logic [ADDR_W-1:0] addr_y,
    input  logic [WIDTH-1:0]  din_y,
    output logic [WIDTH-1:0]  dout_x,
    output logic [WIDTH-1:0]  dout_y
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Port X is applied first so a coinciding Y write is the one kept;
    // the caller also suppresses X on an address match.
    always_ff @(posedge clk) begin
        if (wr_x) mem[addr_x] <= din_x;
        if (wr_y) mem[addr_y] <= din_y;
        dout_x <= mem[addr_x];
        dout_y <= mem[addr_y];
    end

    // R7: a Y write is always present in the array on the following cycle
    p_y_write_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_y |=> (mem[$past(addr_y)] == $past(din_y)));

endmodule

// File: rtl/dpf_port_out.sv
module dpf_port_out
    import dpf_pkg::*;
#(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  out_src_e         src_d,
    input  logic [WIDTH-1:0] fwd_d,
    input  logic [WIDTH-1:0] arr_q,
    input  logic             oe,
    output logic             valid,
    output logic [WIDTH-1:0] data
);

    out_src_e         src_q;
    logic [WIDTH-1:0] fwd_q;

    // Output register: source selector plus captured forward word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= OUT_NONE;
            fwd_q <= '0;
        end else begin
            src_q <= src_d;
            fwd_q <= fwd_d;
        end
    end

    // Output drive, gated by the unregistered enable
    always_comb begin
        valid = 1'b0;
        data  = '0;
        unique case (src_q)
            OUT_NONE: begin
                valid = 1'b0;
            end
            OUT_ARRAY: begin
                valid = oe;
                data  = oe ? arr_q : '0;
            end
            OUT_FWD: begin
                valid = oe;
                data  = oe ? fwd_q : '0;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

    // R9: nothing shows while the enable is low
    p_oe_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!valid && data == '0));

    // R11: reset leaves the register empty
    p_empty_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !valid);

endmodule

// File: rtl/dpf_ram.sv
module dpf_ram
    import dpf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [WIDTH-1:0]  x_wdata,
    input  logic              x_we,
    input  logic              x_fwd,
    input  logic              x_oe,
    output logic [WIDTH-1:0]  x_rdata,
    output logic              x_valid,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [WIDTH-1:0]  y_wdata,
    input  logic              y_we,
    input  logic              y_fwd,
    input  logic              y_oe,
    output logic [WIDTH-1:0]  y_rdata,
    output logic              y_valid
);

    // ---------------- start-up sequencer ----------------
    boot_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WARM;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WARM: st_d = ST_RUN;   // warm done
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_WARM;
        endcase
    end

    // ---------------- input registers ----------------
    logic              live_q, seln_q, sel_q;
    logic [ADDR_W-1:0] xa_q, ya_q;
    logic [WIDTH-1:0]  xd_q, yd_q;
    logic              xwe_q, ywe_q, xfwd_q, yfwd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            seln_q <= 1'b1;
            sel_q  <= 1'b0;
            xa_q   <= '0;
            ya_q   <= '0;
            xd_q   <= '0;
            yd_q   <= '0;
            xwe_q  <= 1'b0;
            ywe_q  <= 1'b0;
            xfwd_q <= 1'b0;
            yfwd_q <= 1'b0;
        end else begin
            live_q <= (st_q == ST_RUN);
            seln_q <= sel_n;
            sel_q  <= sel;
            xa_q   <= x_addr;
            ya_q   <= y_addr;
            xd_q   <= x_wdata;
            yd_q   <= y_wdata;
            xwe_q  <= x_we;
            ywe_q  <= y_we;
            xfwd_q <= x_fwd;
            yfwd_q <= y_fwd;
        end
    end

    // ---------------- access decode ----------------
    logic     active, same_addr, wr_x, wr_y;
    out_src_e src_x, src_y;

    always_comb begin
        active    = live_q && !seln_q && sel_q;
        same_addr = (xa_q == ya_q);
        wr_x      = active && xwe_q && !(ywe_q && same_addr);
        wr_y      = active && ywe_q;

        if (!active)     src_x = OUT_NONE;
        else if (yfwd_q) src_x = OUT_FWD;
        else if (!xwe_q) src_x = OUT_ARRAY;
        else             src_x = OUT_NONE;

        if (!active)     src_y = OUT_NONE;
        else if (xfwd_q) src_y = OUT_FWD;
        else if (!ywe_q) src_y = OUT_ARRAY;
        else             src_y = OUT_NONE;
    end

    // ---------------- array and output stages ----------------
    logic [WIDTH-1:0] rd_x, rd_y;

    dpf_array #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_x   (wr_x),
        .addr_x (xa_q),
        .din_x  (xd_q),
        .wr_y   (wr_y),
        .addr_y (ya_q),
        .din_y  (yd_q),
        .dout_x (rd_x),
        .dout_y (rd_y)
    );

    dpf_port_out #(.WIDTH(WIDTH)) u_xout (
        .clk   (clk),
        .rst_n (rst_n),
        .src_d (src_x),
        .fwd_d (yd_q),
        .arr_q (rd_x),
        .oe    (x_oe),
        .valid (x_valid),
        .data  (x_rdata)
    );

    dpf_port_out #(.WIDTH(WIDTH)) u_yout (
        .clk   (clk),
        .rst_n (rst_n),
        .src_d (src_y),
        .fwd_d (xd_q),
        .arr_q (rd_y),
        .oe    (y_oe),
        .valid (y_valid),
        .data  (y_rdata)
    );

    // ---------------- assertions ----------------
    // R10: the sequencer leaves the warm state after exactly one edge
    p_warm_to_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARM) |=> (st_q == ST_RUN));

    // R10: the edge spent in the warm state yields no live access
    p_warm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARM) |=> !live_q);

    // R4: an incoming forward overrides port X's read
    p_fwd_over_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && yfwd_q) |=> (!x_oe || x_rdata == $past(yd_q)));

    // R8: a deselected access produces no result on either port
    p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (seln_q || !sel_q)) |=> (!x_valid && !y_valid));

endmodule

// File: tb/dpf_ram_test.sv
module dpf_ram_test;

    localparam int AW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_n, sel;
    logic [AW-1:0] x_addr, y_addr;
    logic [DW-1:0] x_wdata, y_wdata;
    logic          x_we, y_we, x_fwd, y_fwd, x_oe, y_oe;
    logic [DW-1:0] x_rdata, y_rdata;
    logic          x_valid, y_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dpf_ram #(.ADDR_W(AW), .WIDTH(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel),
        .x_addr(x_addr), .x_wdata(x_wdata), .x_we(x_we), .x_fwd(x_fwd),
        .x_oe(x_oe), .x_rdata(x_rdata), .x_valid(x_valid),
        .y_addr(y_addr), .y_wdata(y_wdata), .y_we(y_we), .y_fwd(y_fwd),
        .y_oe(y_oe), .y_rdata(y_rdata), .y_valid(y_valid)
    );

    typedef struct packed {
        logic [AW-1:0] xa;
        logic [DW-1:0] xd;
        logic          xwe;
        logic          xfwd;
        logic [AW-1:0] ya;
        logic [DW-1:0] yd;
        logic          ywe;
        logic          yfwd;
        logic          exv;
        logic [DW-1:0] exd;
        logic          eyv;
        logic [DW-1:0] eyd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // xa  xd      we   fwd   ya   yd      we   fwd   xv   xdata   yv   ydata
        '{4'h1, 16'h1111, 1'b1, 1'b0, 4'h2, 16'h2222, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // 0 R11 writes, no result
        '{4'h2, 16'h0000, 1'b0, 1'b0, 4'h1, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h2222, 1'b1, 16'h1111}, // 1 R2 cross reads
        '{4'h1, 16'h0000, 1'b0, 1'b0, 4'h1, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h1111, 1'b1, 16'h1111}, // 2 R5 same-address reads
        '{4'h1, 16'h3333, 1'b1, 1'b0, 4'h1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1111}, // 3 R6 read sees old word
        '{4'h1, 16'h0000, 1'b0, 1'b0, 4'h2, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h3333, 1'b1, 16'h2222}, // 4 R2 new word stored
        '{4'h5, 16'h5555, 1'b1, 1'b0, 4'h5, 16'h6666, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000}, // 5 R7 write clash
        '{4'h5, 16'h0000, 1'b0, 1'b0, 4'h5, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h6666, 1'b1, 16'h6666}, // 6 R7 Y word kept
        '{4'h1, 16'hABCD, 1'b0, 1'b1, 4'h2, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h3333, 1'b1, 16'hABCD}, // 7 R4 forward beats Y read
        '{4'h2, 16'h0000, 1'b0, 1'b0, 4'h5, 16'h1234, 1'b0, 1'b1, 1'b1, 16'h1234, 1'b1, 16'h6666}, // 8 R3 Y to X
        '{4'h1, 16'h0F0F, 1'b0, 1'b1, 4'h2, 16'hF0F0, 1'b0, 1'b1, 1'b1, 16'hF0F0, 1'b1, 16'h0F0F}, // 9 R3 both ways
        '{4'h1, 16'h0000, 1'b0, 1'b0, 4'h3, 16'h7777, 1'b1, 1'b1, 1'b1, 16'h7777, 1'b0, 16'h0000}, // 10 R3 forward while writing
        '{4'h3, 16'h0000, 1'b0, 1'b0, 4'h3, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h7777, 1'b1, 16'h7777}  // 11 R2 forwarded write stored
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R11";
            1, 4, 11: return "R2";
            2:       return "R5";
            3:       return "R6";
            5, 6:    return "R7";
            7:       return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [AW-1:0] xa, logic [DW-1:0] xd, logic xw, logic xf,
                         logic [AW-1:0] ya, logic [DW-1:0] yd, logic yw, logic yf);
        x_addr = xa; x_wdata = xd; x_we = xw; x_fwd = xf;
        y_addr = ya; y_wdata = yd; y_we = yw; y_fwd = yf;
    endtask

    task automatic check_vec(int i);
        check(vtag(i), $sformatf("vec%0d x_valid", i), {15'd0, x_valid}, {15'd0, VECS[i].exv});
        check(vtag(i), $sformatf("vec%0d y_valid", i), {15'd0, y_valid}, {15'd0, VECS[i].eyv});
        if (VECS[i].exv) check(vtag(i), $sformatf("vec%0d x_rdata", i), x_rdata, VECS[i].exd);
        if (VECS[i].eyv) check(vtag(i), $sformatf("vec%0d y_rdata", i), y_rdata, VECS[i].eyd);
    endtask

    function automatic logic [DW-1:0] b(logic v);
        return {15'd0, v};
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b0; sel = 1'b1; x_oe = 1'b1; y_oe = 1'b1;
        drive(4'h0, 16'h0, 1'b0, 1'b0, 4'h0, 16'h0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset x_valid", b(x_valid), 16'd0);
        check("R11", "reset y_valid", b(y_valid), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);   // warm edge passes

        // Vector table, checked two edges after each vector is applied
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) check_vec(i - 2);
            if (i < NV)
                drive(VECS[i].xa, VECS[i].xd, VECS[i].xwe, VECS[i].xfwd,
                      VECS[i].ya, VECS[i].yd, VECS[i].ywe, VECS[i].yfwd);
            else
                drive(4'h1, 16'h0, 1'b0, 1'b0, 4'h1, 16'h0, 1'b0, 1'b0);
            @(negedge clk);
        end

        // R1: latency of two edges (previous capture read address 1)
        drive(4'h3, 16'h0, 1'b0, 1'b0, 4'h1, 16'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1", "x_rdata after one edge", x_rdata, 16'h3333);
        @(negedge clk);
        check("R1", "x_rdata after two edges", x_rdata, 16'h7777);

        // R9: output enable acts without a clock edge
        x_oe = 1'b0;
        #1;
        check("R9", "x_valid with oe low", b(x_valid), 16'd0);
        check("R9", "x_rdata with oe low", x_rdata, 16'h0000);
        x_oe = 1'b1;
        #0.5;
        check("R9", "x_valid with oe high", b(x_valid), 16'd1);
        check("R9", "x_rdata with oe high", x_rdata, 16'h7777);
        @(negedge clk);

        // R8: active-low select high
        sel_n = 1'b1;
        drive(4'h1, 16'h9999, 1'b1, 1'b1, 4'h1, 16'h0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R8", "x_valid deselected", b(x_valid), 16'd0);
        check("R8", "y_valid deselected", b(y_valid), 16'd0);
        // R8: active-high select low
        sel_n = 1'b0; sel = 1'b0;
        drive(4'h1, 16'h8888, 1'b1, 1'b0, 4'h1, 16'h0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R8", "y_valid deselected (sel low)", b(y_valid), 16'd0);
        sel = 1'b1;
        drive(4'h1, 16'h0, 1'b0, 1'b0, 4'h2, 16'h0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R8", "no write while deselected", x_rdata, 16'h3333);

        // R10: first edge after reset ignored
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "x_valid in reset", b(x_valid), 16'd0);
        drive(4'h1, 16'hBEEF, 1'b1, 1'b1, 4'h2, 16'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);   // warm edge captures the write, which is discarded
        drive(4'h1, 16'h0, 1'b0, 1'b0, 4'h2, 16'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10", "no forward from warm edge", b(y_valid), 16'd0);
        @(negedge clk);
        check("R10", "no write from warm edge", x_rdata, 16'h3333);
        check("R10", "port Y live after warm", y_rdata, 16'h2222);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule